// File: doc/BRIEF.md
# Link-List Descriptor Fetcher

This block walks a chain of transfer descriptors held in memory and hands them one at a time to a channel engine. A start pulse makes it read the descriptor at a head address. Each descriptor is four words: source address, destination address, a length word carrying a last-entry flag, and the address of the following descriptor. Once all four words are in, the settings are offered to the channel. The fetcher then waits for the channel to report completion before it follows the next-descriptor address.

A chain ends in one of two ways. A descriptor whose last-entry flag is set ends the walk after its transfer, and the block pulses a list-done output. Without the flag the chain is a ring: the final descriptor points back to the first and the walk carries on. While it reads the four words of one descriptor, the read address steps one word at a time. When the stepped address equals a programmed wrap address, the next read goes to a wrap-to address instead.

Memory reads use a request channel with valid/ready and a response channel that is valid only. A request holds its address until ready is seen. Only one read is ever outstanding, and the fetcher always accepts a response while it waits for one. The settings toward the channel use valid/ready: the settings stay stable until ready. The start, completion and status pins are plain single-cycle or level signals.

Top module: `ll_desc_fetcher`

## Requirements
- R1: After reset, busy, list_done, rd_req_valid and cfg_valid are all low.
- R2: A start pulse while idle gives a first read request at head_ptr on the next cycle, and busy goes high. A start pulse or a change of head_ptr while busy has no effect on the read sequence.
- R3: Each descriptor is read as four one-word reads in the order source, destination, length, next pointer, at consecutive word addresses. No request is made while a read is outstanding.
- R4: While rd_req_valid is high and rd_req_ready is low, rd_req_valid stays high and rd_req_addr stays unchanged.
- R5: After the fourth word, cfg_valid rises with cfg_src = word 0, cfg_dst = word 1, cfg_len = bits [DW-2:0] of word 2, and cfg_last = bit DW-1 of word 2. All of these hold until cfg_ready. No read is requested while cfg_valid is high.
- R6: The read of the following descriptor begins only after a chan_done pulse that arrives after cfg_ready has accepted the settings. A chan_done pulse while the settings are still waiting for acceptance is ignored.
- R7: The first read of each following descriptor is at the address in word 3 of the previous descriptor.
- R8: When the accepted descriptor has bit DW-1 of its length word set, its chan_done ends the walk. list_done pulses for one cycle with busy already low, and no further reads are made.
- R9: When no descriptor has the last-entry flag, the fetcher keeps following pointers: a last descriptor that points to the first one is read again and handed out again.
- R10: With wrap_en high, when the word address after a step equals wrap_at, the next read goes to wrap_to instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, acted on only while idle |
| head_ptr | input | DW | Word address of the first descriptor |
| wrap_en | input | 1 | Enables the address wrap |
| wrap_at | input | DW | Stepped address that triggers the wrap |
| wrap_to | input | DW | Address used in place of wrap_at |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | DW | Read word address |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_data | input | DW | Read data |
| cfg_valid | output | 1 | Descriptor settings valid toward channel |
| cfg_ready | input | 1 | Channel accepts settings |
| cfg_src | output | DW | Source address setting |
| cfg_dst | output | DW | Destination address setting |
| cfg_len | output | DW-1 | Transfer length setting |
| cfg_last | output | 1 | Last-entry flag of this descriptor |
| chan_done | input | 1 | Channel transaction complete pulse |
| busy | output | 1 | Walk in progress |
| list_done | output | 1 | One-cycle pulse at end of a flagged chain |

## Verification
Two functions can land on the same read: the wrap jump and memory back-pressure. This happens when a stalled request is the one whose address came from a wrap. The bench places the first descriptor so that its third word crosses wrap_at, and it throttles rd_req_ready with several stall ratios. It then judges the logged address sequence against one computed by the step rule, and counts any request whose address moved while it was held. A second collision, a stray chan_done while the settings wait for cfg_ready, is judged by the cycle at which the next descriptor's first read appears.

// File: rtl/ll_fetch_pkg.sv
package ll_fetch_pkg;

  localparam int DESC_WORDS = 4;
  localparam int DESC_IDX_W = $clog2(DESC_WORDS);

  // word positions inside a descriptor; the read order follows these
  localparam int W_SRC  = 0;
  localparam int W_DST  = 1;
  localparam int W_LEN  = 2;
  localparam int W_NEXT = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_LOAD,
    ST_RUN,
    ST_NEXT
  } fetch_state_e;

endpackage

// File: rtl/ll_addr_gen.sv
module ll_addr_gen #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_head,
  input  logic [DW-1:0] head,
  input  logic          load_link,
  input  logic [DW-1:0] link,
  input  logic          step,
  input  logic          wrap_en,
  input  logic [DW-1:0] wrap_at,
  input  logic [DW-1:0] wrap_to,
  output logic [DW-1:0] addr
);

  logic [DW-1:0] addr_q;
  logic [DW-1:0] inc;
  logic [DW-1:0] stepped;

  assign inc     = addr_q + DW'(1);
  assign stepped = (wrap_en && (inc == wrap_at)) ? wrap_to : inc;
  assign addr    = addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (load_head) begin
      addr_q <= head;
    end else if (load_link) begin
      addr_q <= link;
    end else if (step) begin
      addr_q <= stepped;
    end
  end

endmodule

// File: rtl/ll_desc_regs.sv
module ll_desc_regs
  import ll_fetch_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                wr_en,
  input  logic [DESC_IDX_W-1:0]               wr_idx,
  input  logic [DW-1:0]                       wr_data,
  output logic [DESC_WORDS-1:0][DW-1:0]       words
);

  for (genvar g = 0; g < DESC_WORDS; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        words[g] <= '0;
      end else if (wr_en && (wr_idx == DESC_IDX_W'(g))) begin
        words[g] <= wr_data;
      end
    end
  end

endmodule

// File: rtl/ll_ctrl.sv
module ll_ctrl
  import ll_fetch_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  rd_req_ready,
  input  logic                  rd_rsp_valid,
  input  logic                  cfg_ready,
  input  logic                  chan_done,
  input  logic                  last_flag,
  output logic                  rd_req_valid,
  output logic                  cap_en,
  output logic [DESC_IDX_W-1:0] cap_idx,
  output logic                  load_head,
  output logic                  load_link,
  output logic                  step,
  output logic                  cfg_valid,
  output logic                  busy,
  output logic                  list_done
);

  fetch_state_e          state_q;
  logic [DESC_IDX_W-1:0] beat_q;
  logic                  wait_q;
  logic                  done_q;
  logic                  last_beat;

  assign last_beat    = (beat_q == DESC_IDX_W'(DESC_WORDS - 1));
  assign rd_req_valid = (state_q == ST_FETCH) && !wait_q;
  assign cap_en       = (state_q == ST_FETCH) && wait_q && rd_rsp_valid;
  assign cap_idx      = beat_q;
  assign step         = cap_en && !last_beat;
  assign load_head    = (state_q == ST_IDLE) && start;
  assign load_link    = (state_q == ST_NEXT) && !last_flag;
  assign cfg_valid    = (state_q == ST_LOAD);
  assign busy         = (state_q != ST_IDLE);
  assign list_done    = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
      wait_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q <= ST_FETCH;
            beat_q  <= '0;
            wait_q  <= 1'b0;
          end
        end
        ST_FETCH: begin
          if (rd_req_valid && rd_req_ready) begin
            wait_q <= 1'b1;
          end
          if (cap_en) begin
            wait_q <= 1'b0;
            if (last_beat) begin
              state_q <= ST_LOAD;
            end else begin
              beat_q <= beat_q + DESC_IDX_W'(1);
            end
          end
        end
        ST_LOAD: begin
          if (cfg_ready) begin
            state_q <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (chan_done) begin
            state_q <= ST_NEXT;
          end
        end
        ST_NEXT: begin
          if (last_flag) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            state_q <= ST_FETCH;
            beat_q  <= '0;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ll_desc_fetcher.sv
module ll_desc_fetcher
  import ll_fetch_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] head_ptr,
  input  logic          wrap_en,
  input  logic [DW-1:0] wrap_at,
  input  logic [DW-1:0] wrap_to,
  output logic          rd_req_valid,
  input  logic          rd_req_ready,
  output logic [DW-1:0] rd_req_addr,
  input  logic          rd_rsp_valid,
  input  logic [DW-1:0] rd_rsp_data,
  output logic          cfg_valid,
  input  logic          cfg_ready,
  output logic [DW-1:0] cfg_src,
  output logic [DW-1:0] cfg_dst,
  output logic [DW-2:0] cfg_len,
  output logic          cfg_last,
  input  logic          chan_done,
  output logic          busy,
  output logic          list_done
);

  localparam int LAST_BIT = DW - 1;

  logic                            cap_en;
  logic [DESC_IDX_W-1:0]           cap_idx;
  logic                            load_head;
  logic                            load_link;
  logic                            step;
  logic [DESC_WORDS-1:0][DW-1:0]   words;

  ll_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .rd_req_ready (rd_req_ready),
    .rd_rsp_valid (rd_rsp_valid),
    .cfg_ready    (cfg_ready),
    .chan_done    (chan_done),
    .last_flag    (cfg_last),
    .rd_req_valid (rd_req_valid),
    .cap_en       (cap_en),
    .cap_idx      (cap_idx),
    .load_head    (load_head),
    .load_link    (load_link),
    .step         (step),
    .cfg_valid    (cfg_valid),
    .busy         (busy),
    .list_done    (list_done)
  );

  ll_addr_gen #(.DW(DW)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_head (load_head),
    .head      (head_ptr),
    .load_link (load_link),
    .link      (words[W_NEXT]),
    .step      (step),
    .wrap_en   (wrap_en),
    .wrap_at   (wrap_at),
    .wrap_to   (wrap_to),
    .addr      (rd_req_addr)
  );

  ll_desc_regs #(.DW(DW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cap_en),
    .wr_idx  (cap_idx),
    .wr_data (rd_rsp_data),
    .words   (words)
  );

  assign cfg_src  = words[W_SRC];
  assign cfg_dst  = words[W_DST];
  assign cfg_len  = words[W_LEN][DW-2:0];
  assign cfg_last = words[W_LEN][LAST_BIT];

endmodule

// File: rtl/ll_desc_fetcher_chk.sv
module ll_desc_fetcher_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [DW-1:0] head_ptr,
  input logic          rd_req_valid,
  input logic          rd_req_ready,
  input logic [DW-1:0] rd_req_addr,
  input logic          rd_rsp_valid,
  input logic          cfg_valid,
  input logic          cfg_ready,
  input logic [DW-1:0] cfg_src,
  input logic [DW-1:0] cfg_dst,
  input logic [DW-2:0] cfg_len,
  input logic          cfg_last,
  input logic          busy,
  input logic          list_done
);

  logic outst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outst_q <= 1'b0;
    end else if (rd_req_valid && rd_req_ready) begin
      outst_q <= 1'b1;
    end else if (rd_rsp_valid) begin
      outst_q <= 1'b0;
    end
  end

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (rd_req_valid && busy && rd_req_addr == $past(head_ptr)));

  p_single_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |-> !outst_q);

  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_addr)));

  p_cfg_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && !cfg_ready) |=>
      (cfg_valid && $stable(cfg_src) && $stable(cfg_dst) && $stable(cfg_len) && $stable(cfg_last)));

  p_no_read_in_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req_valid && cfg_valid));

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    list_done |-> !busy);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    list_done |=> !list_done);

endmodule

bind ll_desc_fetcher ll_desc_fetcher_chk #(.DW(DW)) i_chk (.*);

// File: tb/test_ll_desc_fetcher.sv
module test_ll_desc_fetcher;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_a = 1'b0;
  logic          start_b;
  logic          start;
  logic [DW-1:0] head_a = '0;
  logic          head_alt;
  logic [DW-1:0] head_ptr;
  logic          wrap_en = 1'b0;
  logic [DW-1:0] wrap_at = '0;
  logic [DW-1:0] wrap_to = '0;
  logic          rd_req_valid;
  logic          rd_req_ready;
  logic [DW-1:0] rd_req_addr;
  logic          rd_rsp_valid;
  logic [DW-1:0] rd_rsp_data;
  logic          cfg_valid;
  logic          cfg_ready;
  logic [DW-1:0] cfg_src;
  logic [DW-1:0] cfg_dst;
  logic [DW-2:0] cfg_len;
  logic          cfg_last;
  logic          chan_done;
  logic          busy;
  logic          list_done;

  assign start    = start_a | start_b;
  assign head_ptr = head_alt ? 32'd60 : head_a;

  ll_desc_fetcher #(.DW(DW)) i_ll_desc_fetcher (
    .clk(clk), .rst_n(rst_n), .start(start), .head_ptr(head_ptr),
    .wrap_en(wrap_en), .wrap_at(wrap_at), .wrap_to(wrap_to),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
    .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_src(cfg_src), .cfg_dst(cfg_dst),
    .cfg_len(cfg_len), .cfg_last(cfg_last), .chan_done(chan_done),
    .busy(busy), .list_done(list_done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [31:0] mem [0:63];

  // environment settings per case
  int stall_n = 0, lat_n = 1, cstall = 0;

  // logs filled by the environment model
  logic [31:0] tr_addr [0:63];
  int          tr_cyc  [0:63];
  int          n_tr;
  logic [31:0] lg_src [0:15];
  logic [31:0] lg_dst [0:15];
  logic [30:0] lg_len [0:15];
  logic        lg_last[0:15];
  int          n_cf;
  int          done_cyc [0:15];
  int          n_done;
  int          ld_cnt, ld_busy_err, hold_err;

  // model state
  int          mcnt, dcnt;
  logic [31:0] maddr, prev_addr;
  logic        prev_pend, inj_pend;

  always @(negedge clk) begin
    if (!rst_n) begin
      rd_req_ready = 1'b0; rd_rsp_valid = 1'b0; rd_rsp_data = '0;
      cfg_ready = 1'b0; chan_done = 1'b0; start_b = 1'b0; head_alt = 1'b0;
      n_tr = 0; n_cf = 0; n_done = 0; ld_cnt = 0; ld_busy_err = 0; hold_err = 0;
      mcnt = 0; dcnt = 0; maddr = '0; prev_addr = '0; prev_pend = 1'b0; inj_pend = 1'b1;
    end else begin
      logic r, cr;
      // memory response
      rd_rsp_valid = 1'b0;
      if (mcnt > 0) begin
        mcnt = mcnt - 1;
        if (mcnt == 0) begin
          rd_rsp_valid = 1'b1;
          rd_rsp_data  = mem[maddr[5:0]];
        end
      end
      // request side
      if (prev_pend && (!rd_req_valid || rd_req_addr != prev_addr)) hold_err++;
      r = (stall_n == 0) || ((cyc % (stall_n + 1)) == 0);
      rd_req_ready = r;
      if (rd_req_valid && r) begin
        if (n_tr < 64) begin
          tr_addr[n_tr] = rd_req_addr;
          tr_cyc[n_tr]  = cyc;
        end
        n_tr++;
        maddr = rd_req_addr;
        mcnt  = lat_n;
      end
      prev_pend = rd_req_valid && !r;
      prev_addr = rd_req_addr;
      // channel side
      start_b   = 1'b0;
      chan_done = 1'b0;
      cr = (cstall == 0) || ((cyc % 3) == 0);
      if (dcnt > 0) begin
        dcnt = dcnt - 1;
        if (dcnt == 0) begin
          chan_done = 1'b1;
          if (n_done < 16) done_cyc[n_done] = cyc;
          n_done++;
        end
      end else if (cstall != 0 && inj_pend && cfg_valid && !cr) begin
        chan_done = 1'b1;       // stray completion while settings wait (R6)
        inj_pend  = 1'b0;
      end
      cfg_ready = cr;
      if (cfg_valid && cr) begin
        if (n_cf < 16) begin
          lg_src[n_cf] = cfg_src; lg_dst[n_cf] = cfg_dst;
          lg_len[n_cf] = cfg_len; lg_last[n_cf] = cfg_last;
        end
        n_cf++;
        dcnt = 3;
        if (n_cf == 1) begin
          start_b  = 1'b1;      // start while busy (R2)
          head_alt = 1'b1;
        end
      end
      if (list_done) begin
        ld_cnt++;
        if (busy) ld_busy_err++;
      end
    end
  end

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] stp(input logic [31:0] a);
    logic [31:0] inc;
    inc = a + 32'd1;
    stp = (wrap_en && inc == wrap_at) ? wrap_to : inc;
  endfunction

  function automatic logic [31:0] base_of(input int k);
    base_of = 32'(4 + 12 * k);
  endfunction

  logic [31:0] exp_addr [0:63];
  logic [31:0] e_src [0:3];
  logic [31:0] e_dst [0:3];
  logic [30:0] e_len [0:3];
  logic        e_last[0:3];

  task automatic run_case(input int n, input int st, input int lt, input int cs,
                          input bit wr, input bit ring);
    int nd, ne, t;
    bit ok;
    string tag;
    rst_n = 1'b0;
    stall_n = st; lat_n = lt; cstall = cs;
    wrap_en = wr;
    wrap_at = base_of(0) + 32'd2;
    wrap_to = 32'd52;
    head_a  = base_of(0);
    for (int i = 0; i < 64; i++) mem[i] = 32'hDEAD_0000 + 32'(i);
    for (int k = 0; k < n; k++) begin
      logic [31:0] a;
      logic [31:0] w [0:3];
      e_src[k]  = 32'h1000_0000 + 32'(k * 256 + st * 16 + lt);
      e_dst[k]  = 32'h2000_0000 + 32'(k * 256 + cs * 16 + n);
      e_len[k]  = 31'(100 + k * 7 + lt);
      e_last[k] = (k == n - 1) && !ring;
      w[0] = e_src[k]; w[1] = e_dst[k]; w[2] = {e_last[k], e_len[k]};
      w[3] = (k == n - 1) ? base_of(0) : base_of(k + 1);
      a = base_of(k);
      for (int j = 0; j < 4; j++) begin
        mem[a[5:0]] = w[j];
        exp_addr[4 * k + j] = a;
        a = stp(a);
      end
    end
    nd = ring ? n + 1 : n;
    for (int j = 0; j < 4; j++) exp_addr[4 * n + j] = exp_addr[j];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !list_done && !rd_req_valid && !cfg_valid, "R1", "idle after reset",
        {busy, list_done, rd_req_valid, cfg_valid}, 32'h0);
    start_a = 1'b1;
    @(negedge clk);
    start_a = 1'b0;
    t = 0;
    while (t < 3000 && (ring ? (n_cf < nd) : (ld_cnt == 0))) begin
      @(negedge clk);
      t++;
    end
    if (!ring) repeat (8) @(negedge clk);
    chk(t < 3000, "R8", "walk completes", 32'(t), 32'd3000);
    chk(n_tr > 0 && tr_addr[0] == base_of(0), "R2", "first read at head", tr_addr[0], base_of(0));
    ok = 1'b1;
    for (int i = 0; i < n_tr && i < 64; i++) if (tr_addr[i] == 32'd60) ok = 1'b0;
    chk(ok, "R2", "start while busy ignored", 32'(n_tr), 32'(4 * nd));
    ne = 4 * nd;
    ok = ring ? (n_tr >= ne) : (n_tr == ne);
    for (int i = 0; i < ne && i < n_tr; i++) if (tr_addr[i] != exp_addr[i]) ok = 1'b0;
    tag = ring ? "R9" : (wr ? "R10" : "R3");
    chk(ok, tag, "read address sequence", (n_tr > 2) ? tr_addr[2] : 32'hFFFF_FFFF, exp_addr[2]);
    ok = 1'b1;
    for (int k = 1; k < nd; k++) if (n_tr <= 4 * k || tr_addr[4 * k] != base_of(k % n)) ok = 1'b0;
    chk(ok, "R7", "descriptor starts follow pointers", 32'(n_tr), 32'(ne));
    ok = ring ? (n_cf >= nd) : (n_cf == nd);
    for (int k = 0; k < nd && k < n_cf; k++) begin
      int m;
      m = k % n;
      if (lg_src[k] != e_src[m] || lg_dst[k] != e_dst[m] ||
          lg_len[k] != e_len[m] || lg_last[k] != e_last[m]) ok = 1'b0;
    end
    chk(ok, "R5", "settings handed out", (n_cf > 0) ? lg_src[0] : 32'h0, e_src[0]);
    ok = 1'b1;
    for (int k = 0; k + 1 < nd; k++) begin
      if (n_tr <= 4 * (k + 1) || n_done <= k || tr_cyc[4 * (k + 1)] <= done_cyc[k]) ok = 1'b0;
    end
    chk(ok, "R6", "next read after completion", 32'(n_done), 32'(nd - 1));
    if (st > 0) chk(hold_err == 0, "R4", "held request stable", 32'(hold_err), 32'd0);
    if (ring) begin
      chk(ld_cnt == 0, "R9", "ring raises no list_done", 32'(ld_cnt), 32'd0);
    end else begin
      chk(ld_cnt == 1 && ld_busy_err == 0 && !busy, "R8", "single list_done then idle",
          32'(ld_cnt), 32'd1);
    end
  endtask

  initial begin
    for (int n = 1; n <= 3; n++)
      for (int st = 0; st <= 2; st++)
        for (int lt = 1; lt <= 3; lt++)
          for (int cs = 0; cs <= 1; cs++)
            for (int wr = 0; wr <= 1; wr++)
              run_case(n, st, lt, cs, wr[0], 1'b0);
    for (int n = 1; n <= 3; n++)
      for (int wr = 0; wr <= 1; wr++)
        run_case(n, 1, 2, 1, wr[0], 1'b1);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, 150000);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule